// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block sits between a register bus and the byte engine of an I2C master. Software places one word per bus byte into a single command/data register. A word is either a byte to send or a request to read one byte. Both kinds of word wait in order in one transmit queue. The byte engine takes words from the head of that queue. Bytes the engine receives go into a receive queue, and software drains that queue by reading the same command/data register.

Software can read the fill level of each queue and the depth of each queue. It can program one threshold per queue, and two level flags follow those thresholds. The block raises a one-cycle event when a word is lost or when a read finds no data. When the engine signals an abort, both queues are emptied at once.

Top module: `i2c_cmd_queue`

Register map (word address on `reg_addr`): 0 command/data, 1 transmit level, 2 receive level, 3 transmit threshold, 4 receive threshold, 5 depth parameters. Any other address reads as zero.

## Requirements
- R1: A write to address 0 with bit 8 clear queues `{0, wdata[7:0]}`. The engine receives the queued words in the order they were written. A pop while the queue is empty has no effect.
- R2: A write to address 0 with bit 8 set queues a read request with word value 0x100. Bits 7:0 of such a write are discarded.
- R3: A read of address 0 returns the oldest received byte in bits 7:0, with zeros above it, in the same cycle. That byte is removed from the receive queue at the clock edge.
- R4: Reading address 1 returns the number of transmit entries, and reading address 2 returns the number of receive entries. Both values reflect every push and pop completed up to the previous edge.
- R5: Reading address 5 returns the transmit depth minus one in bits 23:16 and the receive depth minus one in bits 15:8. All other bits read as zero.
- R6: When `eng_abort` is sampled high, both queues are empty after that edge. Any write, pop, push or data read in the same cycle is discarded and raises no event.
- R7: Addresses 3 and 4 hold the transmit and receive thresholds (8 bits, from wdata[7:0]) and read them back. Every value from 0 to depth−1 is accepted.
- R8: `tx_below_thr` is high exactly when the transmit level is less than or equal to the transmit threshold.
- R9: `rx_above_thr` is high exactly when the receive level is greater than the receive threshold.
- R10: A write to address 0 while the transmit queue is full is dropped. Fullness is judged on the state before the edge, even if the engine pops in the same cycle. `tx_over_evt` pulses for the following cycle.
- R11: A read of address 0 while the receive queue is empty returns zero and `rx_under_evt` pulses for the following cycle.
- R12: An engine push into a full receive queue is dropped and `rx_over_evt` pulses for the following cycle. Fullness is judged on the state before the edge.
- R13: After reset both queues are empty and both thresholds are 0. As a result `tx_below_thr` is 1, `rx_above_thr` is 0, and all events are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; side effects only at address 0 |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 9 | Write data; bit 8 marks a read request at address 0 |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| eng_tx_valid | output | 1 | Transmit queue holds at least one word |
| eng_tx_word | output | 9 | Head word: bit 8 read request, bits 7:0 byte |
| eng_tx_pop | input | 1 | Engine consumes the head word |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_abort | input | 1 | Transfer aborted; flush both queues |
| tx_below_thr | output | 1 | Transmit level at or below threshold |
| rx_above_thr | output | 1 | Receive level above threshold |
| tx_over_evt | output | 1 | One-cycle pulse: command write lost |
| rx_under_evt | output | 1 | One-cycle pulse: read of empty receive queue |
| rx_over_evt | output | 1 | One-cycle pulse: received byte lost |

## Verification
The hardest cases to reach are the collisions at a full queue. One is a software write that arrives at a full transmit queue in the same cycle as an engine pop. Another is an abort that lands while writes and pushes are still being issued. To reach them, the stimulus first fills each queue to exactly its depth through the ports, using only level reads to confirm the count. It then issues the colliding strobes in one cycle. A behavioural model built from queues predicts every output on every clock. Level reads issued right after an abort show through the register interface that nothing from the collision cycle was kept.

// File: rtl/i2c_cmd_queue_pkg.sv
// Shared constants and types for the I2C command/receive queue.
package i2c_cmd_queue_pkg;
    localparam int CMD_W  = 9;   // queue word: read flag + byte
    localparam int RD_BIT = 8;   // position of the read-request flag
    localparam int THR_W  = 8;   // threshold register width

    typedef enum logic [2:0] {
        SEL_CMD   = 3'd0,
        SEL_TXLVL = 3'd1,
        SEL_RXLVL = 3'd2,
        SEL_TXTHR = 3'd3,
        SEL_RXTHR = 3'd4,
        SEL_PARAM = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/cmd_ring_fifo.sv
// Ring-buffer FIFO with occupancy count and synchronous flush.
// Assumes: push while full and pop while empty are ignored here; callers
// derive loss/underflow events from full/empty. Flush beats push and pop.
module cmd_ring_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
    endfunction

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp];
    assign level   = cnt;

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and count update; flush and reset empty the ring.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= adv(wp);
            if (do_pop)  rp <= adv(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= LW'(cnt + 1'b1);
                2'b01:   cnt <= LW'(cnt - 1'b1);
                default: cnt <= cnt;
            endcase
        end
    end

    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LW'(DEPTH));
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));
    a_r1_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (cnt == '0));
endmodule

// File: rtl/queue_level_flags.sv
// Threshold comparators for the two queue levels.
// Assumes: levels and thresholds are unsigned; purely combinational.
module queue_level_flags #(
    parameter int TX_LW = 4,
    parameter int RX_LW = 4,
    parameter int T_W   = 8
) (
    input  logic [TX_LW-1:0] tx_level,
    input  logic [RX_LW-1:0] rx_level,
    input  logic [T_W-1:0]   tx_thr,
    input  logic [T_W-1:0]   rx_thr,
    output logic             tx_low,
    output logic             rx_high
);
    // Compare at a common width so that no operand gets truncated.
    always_comb begin
        tx_low  = (32'(tx_level) <= 32'(tx_thr));
        rx_high = (32'(rx_level) >  32'(rx_thr));
    end
endmodule

// File: rtl/i2c_cmd_queue.sv
// Register-side command queue and receive queue of an I2C master.
// Assumes: one register access per cycle; reads are combinational and the
// data-register pop takes effect at the edge that ends the read cycle.
module i2c_cmd_queue
    import i2c_cmd_queue_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [CMD_W-1:0] reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             eng_tx_valid,
    output logic [CMD_W-1:0] eng_tx_word,
    input  logic             eng_tx_pop,
    input  logic             eng_rx_push,
    input  logic [7:0]       eng_rx_byte,
    input  logic             eng_abort,
    output logic             tx_below_thr,
    output logic             rx_above_thr,
    output logic             tx_over_evt,
    output logic             rx_under_evt,
    output logic             rx_over_evt
);
    localparam int TX_LW = $clog2(TX_DEPTH + 1);
    localparam int RX_LW = $clog2(RX_DEPTH + 1);
    localparam logic [31:0] PARAM_WORD =
        {8'h00, 8'(TX_DEPTH - 1), 8'(RX_DEPTH - 1), 8'h00};

    logic             wr_cmd, rd_cmd;
    logic [CMD_W-1:0] tx_din;
    logic [TX_LW-1:0] tx_lvl;
    logic [RX_LW-1:0] rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]       rx_head;
    logic [THR_W-1:0] tx_thr, rx_thr;

    assign wr_cmd = reg_wr && (reg_addr == SEL_CMD);
    assign rd_cmd = reg_rd && (reg_addr == SEL_CMD);

    // Build the queue word: a read request drops the byte field.
    always_comb begin
        if (reg_wdata[RD_BIT]) tx_din = {1'b1, 8'h00};
        else                   tx_din = {1'b0, reg_wdata[7:0]};
    end

    cmd_ring_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(eng_abort),
        .push(wr_cmd), .din(tx_din), .pop(eng_tx_pop),
        .dout(eng_tx_word), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    cmd_ring_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(eng_abort),
        .push(eng_rx_push), .din(eng_rx_byte), .pop(rd_cmd),
        .dout(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    assign eng_tx_valid = !tx_empty;

    // Threshold registers; an abort does not touch them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= '0;
            rx_thr <= '0;
        end else if (reg_wr) begin
            if (reg_addr == SEL_TXTHR) tx_thr <= reg_wdata[THR_W-1:0];
            if (reg_addr == SEL_RXTHR) rx_thr <= reg_wdata[THR_W-1:0];
        end
    end

    queue_level_flags #(.TX_LW(TX_LW), .RX_LW(RX_LW), .T_W(THR_W)) u_flags (
        .tx_level(tx_lvl), .rx_level(rx_lvl),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_low(tx_below_thr), .rx_high(rx_above_thr)
    );

    // One-cycle loss and underflow events, suppressed by an abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_over_evt  <= 1'b0;
            rx_under_evt <= 1'b0;
            rx_over_evt  <= 1'b0;
        end else begin
            tx_over_evt  <= !eng_abort && wr_cmd && tx_full;
            rx_under_evt <= !eng_abort && rd_cmd && rx_empty;
            rx_over_evt  <= !eng_abort && eng_rx_push && rx_full;
        end
    end

    // Read-data multiplexer.
    always_comb begin
        case (reg_addr)
            SEL_CMD:   reg_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
            SEL_TXLVL: reg_rdata = 32'(tx_lvl);
            SEL_RXLVL: reg_rdata = 32'(rx_lvl);
            SEL_TXTHR: reg_rdata = 32'(tx_thr);
            SEL_RXTHR: reg_rdata = 32'(rx_thr);
            SEL_PARAM: reg_rdata = PARAM_WORD;
            default:   reg_rdata = 32'h0;
        endcase
    end

    a_r10_tx_loss_event: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && tx_full && !eng_abort) |=> tx_over_evt);
    a_r12_rx_loss_event: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !eng_abort) |=> rx_over_evt);
    a_r11_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && rx_empty) |-> (reg_rdata == 32'h0));
    a_r2_request_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_valid && eng_tx_word[RD_BIT]) |-> (eng_tx_word[7:0] == 8'h00));
    a_r6_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> !(tx_over_evt || rx_under_evt || rx_over_evt));
endmodule

// File: tb/sim_i2c_cmd_queue.sv
// Bench: behavioural queue model compared against the block every cycle.
module sim_i2c_cmd_queue;
    localparam int CLK_T = 10;
    localparam int TXD   = 8;
    localparam int RXD   = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0, eng_tx_pop = 0, eng_rx_push = 0, eng_abort = 0;
    logic [2:0]  reg_addr = 0;
    logic [8:0]  reg_wdata = 0;
    logic [7:0]  eng_rx_byte = 0;
    logic [31:0] reg_rdata;
    logic        eng_tx_valid, tx_below_thr, rx_above_thr;
    logic        tx_over_evt, rx_under_evt, rx_over_evt;
    logic [8:0]  eng_tx_word;

    int checks = 0, errors = 0, cycles = 0;

    // Model state.
    logic [8:0] txq[$];
    logic [7:0] rxq[$];
    logic [7:0] m_txthr = 0, m_rxthr = 0;
    logic       m_txo = 0, m_rxu = 0, m_rxo = 0;

    i2c_cmd_queue #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_word(eng_tx_word),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_byte(eng_rx_byte), .eng_abort(eng_abort),
        .tx_below_thr(tx_below_thr), .rx_above_thr(rx_above_thr),
        .tx_over_evt(tx_over_evt), .rx_under_evt(rx_under_evt),
        .rx_over_evt(rx_over_evt)
    );

    always #(CLK_T/2) clk = ~clk;

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: act=%0d exp<=20000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Reference model update at each edge.
    always @(posedge clk) begin
        bit txf, rxf, rxe, wr, rd;
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_txthr = 0; m_rxthr = 0; m_txo = 0; m_rxu = 0; m_rxo = 0;
        end else begin
            m_txo = 0; m_rxu = 0; m_rxo = 0;
            wr  = reg_wr && reg_addr == 0;
            rd  = reg_rd && reg_addr == 0;
            txf = txq.size() == TXD;
            rxf = rxq.size() == RXD;
            rxe = rxq.size() == 0;
            if (reg_wr && reg_addr == 3) m_txthr = reg_wdata[7:0];
            if (reg_wr && reg_addr == 4) m_rxthr = reg_wdata[7:0];
            if (eng_abort) begin
                txq.delete(); rxq.delete();
            end else begin
                if (eng_tx_pop && txq.size() > 0) void'(txq.pop_front());
                if (wr) begin
                    if (txf) m_txo = 1;
                    else txq.push_back(reg_wdata[8] ? 9'h100 : {1'b0, reg_wdata[7:0]});
                end
                if (rd) begin
                    if (rxe) m_rxu = 1; else void'(rxq.pop_front());
                end
                if (eng_rx_push) begin
                    if (rxf) m_rxo = 1; else rxq.push_back(eng_rx_byte);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return (rxq.size() > 0) ? {24'h0, rxq[0]} : 32'h0;
            3'd1: return 32'(txq.size());
            3'd2: return 32'(rxq.size());
            3'd3: return {24'h0, m_txthr};
            3'd4: return {24'h0, m_rxthr};
            3'd5: return {8'h0, 8'(TXD-1), 8'(RXD-1), 8'h0};
            default: return 32'h0;
        endcase
    endfunction

    // Compare every visible output with the model.
    task automatic compare_all();
        logic [31:0] e;
        chk(eng_tx_valid == (txq.size() > 0), "R1 tx valid", 32'(eng_tx_valid), 32'(txq.size() > 0));
        if (txq.size() > 0)
            chk(eng_tx_word == txq[0], txq[0][8] ? "R2 request word" : "R1 head word",
                32'(eng_tx_word), 32'(txq[0]));
        chk(tx_below_thr == (txq.size() <= int'(m_txthr)), "R8 tx flag",
            32'(tx_below_thr), 32'(txq.size() <= int'(m_txthr)));
        chk(rx_above_thr == (rxq.size() > int'(m_rxthr)), "R9 rx flag",
            32'(rx_above_thr), 32'(rxq.size() > int'(m_rxthr)));
        chk(tx_over_evt == m_txo, "R10 tx loss event", 32'(tx_over_evt), 32'(m_txo));
        chk(rx_under_evt == m_rxu, "R11 underflow event", 32'(rx_under_evt), 32'(m_rxu));
        chk(rx_over_evt == m_rxo, "R12 rx loss event", 32'(rx_over_evt), 32'(m_rxo));
        if (reg_rd) begin
            e = exp_read(reg_addr);
            chk(reg_rdata == e,
                reg_addr == 0 ? "R3 R11 data read" : reg_addr == 5 ? "R5 param read" :
                (reg_addr == 3 || reg_addr == 4) ? "R7 threshold read" : "R4 level read",
                reg_rdata, e);
        end
    endtask

    // One cycle of stimulus: drive after the falling edge, compare, wait.
    task automatic cyc(input bit wr, input bit rd, input logic [2:0] a, input logic [8:0] wd,
                       input bit pop, input bit push, input logic [7:0] b, input bit ab);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        eng_tx_pop = pop; eng_rx_push = push; eng_rx_byte = b; eng_abort = ab;
        #1;
        compare_all();
    endtask

    task automatic idle();               cyc(0,0,0,0,0,0,0,0); endtask
    task automatic wreg(input logic [2:0] a, input logic [8:0] d); cyc(1,0,a,d,0,0,0,0); endtask
    task automatic rreg(input logic [2:0] a); cyc(0,1,a,0,0,0,0,0); endtask
    task automatic epop();               cyc(0,0,0,0,1,0,0,0); endtask
    task automatic epush(input logic [7:0] b); cyc(0,0,0,0,0,1,b,0); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state seen at the ports.
        idle();
        chk(tx_below_thr == 1 && rx_above_thr == 0 && !eng_tx_valid, "R13 reset flags",
            {tx_below_thr, rx_above_thr, eng_tx_valid}, 3'b100);
        for (int a = 0; a < 8; a++) rreg(3'(a));   // R4 R5 R7 R11 readback
        // R1 R2: bytes and a read request in one queue.
        wreg(0, 9'h011); wreg(0, 9'h022); wreg(0, 9'h1AB); wreg(0, 9'h033);
        rreg(1);
        repeat (5) epop();                          // last pop on empty: R1 no effect
        rreg(1);
        // R10: fill transmit queue, overflow, then overflow with a concurrent pop.
        for (int i = 0; i < TXD; i++) wreg(0, 9'(i + 8'h40));
        wreg(0, 9'h0EE);
        cyc(1,0,0,9'h0DD,1,0,0,0);
        idle(); rreg(1);
        // R7 R8: transmit threshold at depth-1.
        wreg(3, 9'(TXD-1)); rreg(3);
        repeat (TXD) epop();
        idle();
        // R12: fill receive queue, overflow, overflow with a concurrent read.
        for (int i = 0; i < RXD; i++) epush(8'(8'hA0 + i));
        epush(8'h5A);
        cyc(0,1,0,0,0,1,8'h77,0);
        idle(); rreg(2);
        // R3 R9 R11: threshold 3, drain, then read empty.
        wreg(4, 9'd3); rreg(4);
        repeat (RXD + 2) rreg(0);
        idle();
        // Simultaneous push and read on an empty receive queue.
        cyc(0,1,0,0,0,1,8'h3C,0);
        rreg(0);
        // R6: abort with concurrent write, pop, push and read.
        wreg(0, 9'h012); wreg(0, 9'h134); epush(8'h56); epush(8'h78);
        cyc(1,1,0,9'h099,1,1,8'h9A,1);
        idle();
        @(negedge clk); reg_rd = 1; reg_addr = 1; #1;
        chk(reg_rdata == 0, "R6 tx level after abort", reg_rdata, 0);
        compare_all();
        @(negedge clk); reg_addr = 2; #1;
        chk(reg_rdata == 0, "R6 rx level after abort", reg_rdata, 0);
        compare_all();
        // Thresholds survive the abort (R7), queues work again.
        rreg(3); rreg(4);
        wreg(0, 9'h0C3); epush(8'h11); rreg(0); epop(); idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule